// File: doc/BRIEF.md
# Processor Trap Entry Unit

This block performs the architectural state change a processor core makes when it takes an exception. The pipeline presents a request together with the exception code, the faulting PC and next-PC, the faulting data address, and the current state: the 16-bit processor state word, the condition codes, the window pointer, the count of windows that can be saved, the trap base address and the pending-interrupt vector.

The block accepts the request in a single clock edge. On that edge it commits every result: the new fetch PC and NPC pointing into the trap table, the saved trap PC, NPC and state word, the trap type, the raised trap level, the new processor state flags, the adjusted window pointer, captured fault addresses for translation misses and access faults, and the pending-interrupt vector with the serviced bit cleared. Soft exceptions skip trap entry and only restart fetch at the faulting instruction.

Exception codes: 0 means "no exception"; 1, 2 and 3 are soft (in-place flush) codes; 8 is an instruction translation miss, 9 a data translation miss, 10 an instruction access fault, 11 a data access fault; 12 is a clean-window trap, 13 a window overflow and 14 a window underflow; 32 to 47 are the sixteen external interrupts. Any other code below 64 is an ordinary trap.

Top module: `trap_entry`

## Requirements
- R1: For a trap (any code that is not soft), pc_o becomes tba_i OR (code << 5) and npc_o becomes pc_o + 4.
- R2: A trap raises tl_o by one, saturating at TL_MAX (default 5); tl_err pulses with ack when the new level equals TL_MAX.
- R3: A trap copies fault_pc into tpc_o and fault_npc into tnpc_o.
- R4: A trap writes tstate_o = pstate_i | (cc_i << 24) | (cwp_i << 16), using the window pointer before adjustment, and writes the code into tt_o.
- R5: A trap sets privileged (pstate bit 2) and alternate globals (bit 0) and clears interrupt enable (bit 1) and instruction-translation enable (bit 3); other bits pass through.
- R6: Data-translation enable (pstate bit 4) is cleared for codes 8, 9, 10 and 11 and set for every other trap.
- R7: For code 8 the address fault_pc, and for code 9 the address fault_addr, goes to badaddr_o; tag_o gets that address with the page-offset bits (PAGE_BYTES, default 4096) cleared and bit 0 set.
- R8: Code 10 writes fault_pc and code 11 writes fault_addr to badaddr_o, leaving tag_o unchanged.
- R9: The window pointer moves modulo NWIN (default 8): +1 for code 12, +2 for code 13 with ovf_flush low, +cansave_i+2 for code 13 with ovf_flush high, -1 for code 14; other codes leave cwp_o = cwp_i.
- R10: Codes 32 to 47 clear bit (code - 32) of int_pend_i into int_pend_o; every other code copies int_pend_i unchanged.
- R11: Soft codes 1 to 3 set pc_o = fault_pc and npc_o = fault_npc, pstate_o = pstate_i, cwp_o = cwp_i, and leave tl_o and all saved trap registers unchanged.
- R12: bad_code pulses with ack when the code is 0 or at least CODE_LIMIT (default 64); the trap entry is still performed.
- R13: A request is accepted when req is high and busy is low; ack and busy are high for exactly the cycle after acceptance, and a request during that cycle is ignored.
- R14: During and after reset every output register, ack and busy are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Exception request |
| code | input | CODE_W (8) | Exception code |
| ovf_flush | input | 1 | Overflow was caused by a flush-windows instruction |
| fault_pc | input | XLEN (32) | Faulting PC |
| fault_npc | input | XLEN (32) | Faulting next PC |
| fault_addr | input | XLEN (32) | Faulting data address |
| pstate_i | input | 16 | Current processor state word |
| cc_i | input | 8 | Condition codes |
| cwp_i | input | $clog2(NWIN) (3) | Current window pointer |
| cansave_i | input | $clog2(NWIN) (3) | Saveable window count |
| tba_i | input | XLEN (32) | Trap base address |
| int_pend_i | input | 16 | Pending interrupt vector |
| ack | output | 1 | Request committed last edge |
| busy | output | 1 | Requests are ignored this cycle |
| bad_code | output | 1 | Invalid exception code pulse |
| tl_err | output | 1 | Trap level reached maximum pulse |
| pc_o | output | XLEN (32) | New fetch PC |
| npc_o | output | XLEN (32) | New fetch next PC |
| pstate_o | output | 16 | New processor state word |
| cwp_o | output | $clog2(NWIN) (3) | New window pointer |
| tl_o | output | $clog2(TL_MAX+1) (3) | Trap level |
| tpc_o | output | XLEN (32) | Saved trap PC |
| tnpc_o | output | XLEN (32) | Saved trap next PC |
| tstate_o | output | XLEN (32) | Saved trap state word |
| tt_o | output | CODE_W (8) | Trap type |
| badaddr_o | output | XLEN (32) | Captured fault address |
| tag_o | output | XLEN (32) | Translation miss tag |
| int_pend_o | output | 16 | Pending vector after clearing |

## Verification
The hardest conditions to reach are the trap-level ceiling and a request arriving in the busy cycle. The stimulus drives more traps in a row than TL_MAX allows without returning, so the level saturates and the error pulse appears on every further entry, then resets mid-run to start over. A request held high across two edges checks that only one acknowledge follows, and window-pointer cases start at the ends of the range so each adjustment wraps.

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int XLEN       = 32,
  parameter int CODE_W     = 8,
  parameter int NWIN       = 8,
  parameter int PAGE_BYTES = 4096,
  parameter int TL_MAX     = 5,
  parameter int CODE_LIMIT = 64,
  localparam int CWP_W     = $clog2(NWIN),
  localparam int TL_W      = $clog2(TL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CODE_W-1:0] code,
  input  logic              ovf_flush,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic [XLEN-1:0]   fault_npc,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic [15:0]       pstate_i,
  input  logic [7:0]        cc_i,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [CWP_W-1:0]  cansave_i,
  input  logic [XLEN-1:0]   tba_i,
  input  logic [15:0]       int_pend_i,
  output logic              ack,
  output logic              busy,
  output logic              bad_code,
  output logic              tl_err,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic [15:0]       pstate_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic [TL_W-1:0]   tl_o,
  output logic [XLEN-1:0]   tpc_o,
  output logic [XLEN-1:0]   tnpc_o,
  output logic [XLEN-1:0]   tstate_o,
  output logic [CODE_W-1:0] tt_o,
  output logic [XLEN-1:0]   badaddr_o,
  output logic [XLEN-1:0]   tag_o,
  output logic [15:0]       int_pend_o
);
  localparam logic [CODE_W-1:0] C_ITLB  = CODE_W'(8);
  localparam logic [CODE_W-1:0] C_DTLB  = CODE_W'(9);
  localparam logic [CODE_W-1:0] C_IFLT  = CODE_W'(10);
  localparam logic [CODE_W-1:0] C_DFLT  = CODE_W'(11);
  localparam logic [CODE_W-1:0] C_CLEAN = CODE_W'(12);
  localparam logic [CODE_W-1:0] C_OVF   = CODE_W'(13);
  localparam logic [CODE_W-1:0] C_UNF   = CODE_W'(14);
  localparam logic [CODE_W-1:0] C_IRQ0  = CODE_W'(32);
  localparam int B_AG = 0, B_IE = 1, B_PRIV = 2, B_ITE = 3, B_DTE = 4;
  localparam int EW = CWP_W + 2;
  localparam logic [EW-1:0] NWIN_E = EW'(NWIN);
  localparam logic [XLEN-1:0] PAGE_MASK = ~XLEN'(PAGE_BYTES - 1);
  localparam logic [TL_W-1:0] TL_TOP = TL_W'(TL_MAX);

  logic accept, is_soft, is_mem, is_irq, was_soft_q;
  logic [XLEN-1:0] vec, miss_addr;
  logic [15:0] ps_trap, irq_clr;
  logic [EW-1:0] cwp_ext, cwp_sum;
  logic [CWP_W-1:0] cwp_nx;
  logic [TL_W-1:0] tl_nx;
  logic [3:0] irq_idx;

  assign busy    = ack;
  assign accept  = req && !ack;
  assign is_soft = (code >= CODE_W'(1)) && (code <= CODE_W'(3));
  assign is_mem  = (code >= C_ITLB) && (code <= C_DFLT);
  assign is_irq  = (code >= C_IRQ0) && (code < C_IRQ0 + CODE_W'(16));
  assign vec     = tba_i | (XLEN'(code) << 5);
  assign irq_idx = 4'(code - C_IRQ0);
  assign irq_clr = is_irq ? (16'd1 << irq_idx) : 16'd0;
  assign tl_nx   = (tl_o < TL_TOP) ? tl_o + TL_W'(1) : tl_o;
  assign miss_addr = (code == C_ITLB) ? fault_pc : fault_addr;

  always_comb begin
    ps_trap = pstate_i;
    ps_trap[B_PRIV] = 1'b1;
    ps_trap[B_AG]   = 1'b1;
    ps_trap[B_IE]   = 1'b0;
    ps_trap[B_ITE]  = 1'b0;
    ps_trap[B_DTE]  = !is_mem;
  end

  always_comb begin
    cwp_ext = EW'(cwp_i);
    case (code)
      C_CLEAN: cwp_sum = cwp_ext + EW'(1);
      C_OVF:   cwp_sum = ovf_flush ? cwp_ext + EW'(cansave_i) + EW'(2) : cwp_ext + EW'(2);
      C_UNF:   cwp_sum = cwp_ext + NWIN_E - EW'(1);
      default: cwp_sum = cwp_ext;
    endcase
    cwp_nx = CWP_W'(cwp_sum % NWIN_E);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; bad_code <= 1'b0; tl_err <= 1'b0; was_soft_q <= 1'b0;
      pc_o <= '0; npc_o <= '0; pstate_o <= '0; cwp_o <= '0; tl_o <= '0;
      tpc_o <= '0; tnpc_o <= '0; tstate_o <= '0; tt_o <= '0;
      badaddr_o <= '0; tag_o <= '0; int_pend_o <= '0;
    end else begin
      ack        <= accept;
      bad_code   <= 1'b0;
      tl_err     <= 1'b0;
      if (accept) begin
        was_soft_q <= is_soft;
        int_pend_o <= int_pend_i & ~irq_clr;
        if (is_soft) begin
          pc_o     <= fault_pc;
          npc_o    <= fault_npc;
          pstate_o <= pstate_i;
          cwp_o    <= cwp_i;
        end else begin
          pc_o     <= vec;
          npc_o    <= vec + XLEN'(4);
          pstate_o <= ps_trap;
          cwp_o    <= cwp_nx;
          tl_o     <= tl_nx;
          tl_err   <= (tl_nx == TL_TOP);
          bad_code <= (code == '0) || (code >= CODE_W'(CODE_LIMIT));
          tpc_o    <= fault_pc;
          tnpc_o   <= fault_npc;
          tstate_o <= XLEN'(pstate_i) | (XLEN'(cc_i) << 24) | (XLEN'(cwp_i) << 16);
          tt_o     <= code;
          if (code == C_ITLB || code == C_DTLB) begin
            badaddr_o <= miss_addr;
            tag_o     <= (miss_addr & PAGE_MASK) | XLEN'(1);
          end else if (code == C_IFLT) begin
            badaddr_o <= fault_pc;
          end else if (code == C_DFLT) begin
            badaddr_o <= fault_addr;
          end
        end
      end
    end
  end

  assert_single_ack_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_level_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !was_soft_q && $past(tl_o) < TL_TOP) |-> tl_o == $past(tl_o) + TL_W'(1));
  assert_level_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tl_err |-> (ack && tl_o == TL_TOP));
  assert_soft_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && was_soft_q) |-> $stable(tl_o) && $stable(tpc_o));
  assert_priv_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !was_soft_q) |-> pstate_o[B_PRIV] && pstate_o[B_AG] && !pstate_o[B_IE] && !pstate_o[B_ITE]);
  assert_npc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !was_soft_q) |-> npc_o == pc_o + XLEN'(4));
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> $stable(tpc_o) && $stable(pc_o) && $stable(tl_o));
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $countones(int_pend_o) <= $countones($past(int_pend_i)));
endmodule

// File: tb/tb_trap_entry.sv
module tb_trap_entry;
  typedef struct {
    logic [31:0] pc, npc, tpc, tnpc, tstate, bad, tag;
    logic [15:0] ps, pend;
    logic [2:0]  cwp, tl;
    logic [7:0]  tt;
    logic        tlerr, badc;
  } exp_t;

  logic clk = 0, rst_n = 0, req = 0, ovf_flush = 0;
  logic [7:0] code = 0, cc_i = 0, tt_o;
  logic [31:0] fault_pc = 0, fault_npc = 0, fault_addr = 0, tba_i = 0;
  logic [15:0] pstate_i = 0, int_pend_i = 0, pstate_o, int_pend_o;
  logic [2:0] cwp_i = 0, cansave_i = 0, cwp_o, tl_o;
  logic ack, busy, bad_code, tl_err;
  logic [31:0] pc_o, npc_o, tpc_o, tnpc_o, tstate_o, badaddr_o, tag_o;

  int n_chk = 0, n_fail = 0;
  exp_t q[$];
  exp_t m;

  always #5 clk = ~clk;

  trap_entry dut (.clk(clk), .rst_n(rst_n), .req(req), .code(code), .ovf_flush(ovf_flush),
    .fault_pc(fault_pc), .fault_npc(fault_npc), .fault_addr(fault_addr), .pstate_i(pstate_i),
    .cc_i(cc_i), .cwp_i(cwp_i), .cansave_i(cansave_i), .tba_i(tba_i), .int_pend_i(int_pend_i),
    .ack(ack), .busy(busy), .bad_code(bad_code), .tl_err(tl_err), .pc_o(pc_o), .npc_o(npc_o),
    .pstate_o(pstate_o), .cwp_o(cwp_o), .tl_o(tl_o), .tpc_o(tpc_o), .tnpc_o(tnpc_o),
    .tstate_o(tstate_o), .tt_o(tt_o), .badaddr_o(badaddr_o), .tag_o(tag_o), .int_pend_o(int_pend_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    m.pc = 0; m.npc = 0; m.tpc = 0; m.tnpc = 0; m.tstate = 0; m.bad = 0; m.tag = 0;
    m.ps = 0; m.pend = 0; m.cwp = 0; m.tl = 0; m.tt = 0; m.tlerr = 0; m.badc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req = 0;
    repeat (2) @(negedge clk);
    chk(ack == 0 && busy == 0, "R14 ack/busy in reset", {30'd0, ack, busy}, 0);
    chk(pc_o == 0 && tpc_o == 0 && tstate_o == 0 && badaddr_o == 0, "R14 regs in reset", pc_o | tpc_o, 0);
    chk(tl_o == 0 && int_pend_o == 0 && pstate_o == 0, "R14 level in reset", 32'(tl_o), 0);
    rst_n = 1; clear_model();
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, input logic fl, input logic [31:0] pc, input logic [31:0] npc,
                      input logic [31:0] da, input logic [15:0] ps, input logic [7:0] cc,
                      input logic [2:0] w, input logic [2:0] cs, input logic [31:0] tba,
                      input logic [15:0] pend, input int hold);
    exp_t e;
    int nw;
    e = m; e.tlerr = 0; e.badc = 0;
    e.pend = pend;
    if (c >= 32 && c <= 47) e.pend[c - 32] = 1'b0;           // R10
    if (c >= 1 && c <= 3) begin                               // R11
      e.pc = pc; e.npc = npc; e.ps = ps; e.cwp = w;
    end else begin
      e.pc = tba | (32'(c) << 5); e.npc = e.pc + 4;          // R1
      e.tl = (m.tl < 5) ? m.tl + 1 : m.tl; e.tlerr = (e.tl == 5); // R2
      e.tpc = pc; e.tnpc = npc;                               // R3
      e.tstate = 32'(ps) | (32'(cc) << 24) | (32'(w) << 16); e.tt = c; // R4
      e.ps = ps; e.ps[2] = 1; e.ps[0] = 1; e.ps[1] = 0; e.ps[3] = 0;   // R5
      e.ps[4] = !(c >= 8 && c <= 11);                         // R6
      e.badc = (c == 0) || (c >= 64);                         // R12
      nw = int'(w);
      if (c == 12) nw = nw + 1;                               // R9
      else if (c == 13) nw = fl ? nw + int'(cs) + 2 : nw + 2;
      else if (c == 14) nw = nw + 7;
      e.cwp = 3'(nw % 8);
      if (c == 8)  begin e.bad = pc; e.tag = (pc & ~32'hFFF) | 1; end // R7
      if (c == 9)  begin e.bad = da; e.tag = (da & ~32'hFFF) | 1; end
      if (c == 10) e.bad = pc;                                // R8
      if (c == 11) e.bad = da;
    end
    m = e;
    @(negedge clk);
    code = c; ovf_flush = fl; fault_pc = pc; fault_npc = npc; fault_addr = da; pstate_i = ps;
    cc_i = cc; cwp_i = w; cansave_i = cs; tba_i = tba; int_pend_i = pend; req = 1;
    q.push_back(e);
    repeat (hold) @(negedge clk);
    req = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && ack) begin
      chk(busy == 1, "R13 busy with ack", 32'(busy), 1);
      if (q.size() == 0) chk(0, "R13 unexpected ack", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(pc_o == e.pc, "R1/R11 pc", pc_o, e.pc);
        chk(npc_o == e.npc, "R1/R11 npc", npc_o, e.npc);
        chk(tl_o == e.tl, "R2 level", 32'(tl_o), 32'(e.tl));
        chk(tl_err == e.tlerr, "R2 level error", 32'(tl_err), 32'(e.tlerr));
        chk(tpc_o == e.tpc && tnpc_o == e.tnpc, "R3 saved pc", tpc_o, e.tpc);
        chk(tstate_o == e.tstate, "R4 tstate", tstate_o, e.tstate);
        chk(tt_o == e.tt, "R4 trap type", 32'(tt_o), 32'(e.tt));
        chk(pstate_o == e.ps, "R5/R6 pstate", 32'(pstate_o), 32'(e.ps));
        chk(badaddr_o == e.bad, "R7/R8 badaddr", badaddr_o, e.bad);
        chk(tag_o == e.tag, "R7/R8 tag", tag_o, e.tag);
        chk(cwp_o == e.cwp, "R9 cwp", 32'(cwp_o), 32'(e.cwp));
        chk(int_pend_o == e.pend, "R10 pending", 32'(int_pend_o), 32'(e.pend));
        chk(bad_code == e.badc, "R12 bad code", 32'(bad_code), 32'(e.badc));
      end
    end
  end

  initial begin
    #2000000;
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_model();
    do_reset();
    send(8,  0, 32'h0001_2344, 32'h0001_2348, 32'h0,         16'h0012, 8'hA5, 3, 0, 32'h4000_0000, 16'h00F0, 1);
    send(9,  0, 32'h0000_2000, 32'h0000_2004, 32'h0000_5ABC, 16'h001A, 8'h0C, 2, 0, 32'h4000_0000, 16'h00F0, 1);
    send(10, 0, 32'h0000_3010, 32'h0000_3014, 32'h0000_7777, 16'h0000, 8'h01, 1, 0, 32'h4000_0000, 16'h0000, 1);
    send(11, 0, 32'h0000_3020, 32'h0000_3024, 32'h0BAD_0008, 16'h0002, 8'h02, 0, 0, 32'h4000_0000, 16'h0000, 1);
    send(12, 0, 32'h0000_4000, 32'h0000_4004, 32'h0,         16'h0012, 8'h03, 7, 0, 32'h8000_0000, 16'h0000, 1);
    send(13, 0, 32'h0000_4100, 32'h0000_4104, 32'h0,         16'h0012, 8'h04, 6, 0, 32'h8000_0000, 16'h0000, 1);
    send(14, 0, 32'h0000_4200, 32'h0000_4204, 32'h0,         16'h0012, 8'h05, 0, 0, 32'h8000_0000, 16'h0000, 1);
    do_reset();
    send(13, 1, 32'h0000_5000, 32'h0000_5004, 32'h0,         16'h0000, 8'h06, 3, 5, 32'h0010_0000, 16'h0000, 1);
    send(13, 1, 32'h0000_5010, 32'h0000_5014, 32'h0,         16'h0000, 8'h06, 7, 7, 32'h0010_0000, 16'h0000, 1);
    send(32, 0, 32'h0000_6000, 32'h0000_6004, 32'h0,         16'h0002, 8'h00, 1, 0, 32'h0010_0000, 16'hFFFF, 1);
    send(47, 0, 32'h0000_6100, 32'h0000_6104, 32'h0,         16'h0002, 8'h00, 1, 0, 32'h0010_0000, 16'hFFFF, 1);
    send(2,  0, 32'h0000_7000, 32'h0000_7008, 32'h0,         16'h0013, 8'h00, 4, 0, 32'h0010_0000, 16'h0101, 1);
    send(16, 0, 32'h0000_7100, 32'h0000_7104, 32'h0,         16'h0000, 8'hFF, 5, 0, 32'h0010_0000, 16'h0000, 1);
    send(0,  0, 32'h0000_7200, 32'h0000_7204, 32'h0,         16'h0000, 8'h00, 5, 0, 32'h0020_0000, 16'h0000, 1);
    send(80, 0, 32'h0000_7300, 32'h0000_7304, 32'h0,         16'h0000, 8'h00, 5, 0, 32'h0020_0000, 16'h0000, 1);
    send(1,  0, 32'h0000_7400, 32'h0000_7404, 32'h0,         16'h0004, 8'h00, 2, 0, 32'h0020_0000, 16'h0000, 2);
    send(3,  0, 32'h0000_7500, 32'h0000_7504, 32'h0,         16'h0004, 8'h00, 2, 0, 32'h0020_0000, 16'h0000, 1);
    send(33, 0, 32'h0000_7600, 32'h0000_7604, 32'h0,         16'h0000, 8'h00, 2, 0, 32'h0020_0000, 16'h0003, 2);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R13 all requests acknowledged once", 32'(q.size()), 0);
    chk(tl_o == 5, "R2 level saturated", 32'(tl_o), 5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule